// File: doc/BRIEF.md
# Store-to-Load Forwarding Unit

This block keeps a small queue of stores that have not yet drained to the cache. It answers forwarding queries from a two-stage load pipeline. Each entry holds the store's virtual and physical doubleword addresses, an 8-bit byte-enable, 64 bits of data, and a four-state lifecycle. The lifecycle records whether the address, the data, or both have arrived.

A load presents its doubleword addresses, its byte-enable and a precomputed bit vector marking which queue entries are older than it. In the same cycle the unit returns an early per-byte forward vector and an early data-pending flag. One cycle later it returns the following:
- the final forward vector and the merged forwarded bytes;
- a data-pending flag with the index of the entry that blocks the load;
- a flag raised when virtual-address and physical-address matching disagree.

The pipeline uses that last flag to request a flush. Byte-enable writes into the queue go through a two-cycle write path.

Each entry follows a lifecycle with four states:
- **ENT_FREE**: nothing is valid.
- **ENT_ADDR**: only the address has arrived.
- **ENT_DATA**: only the data has arrived.
- **ENT_FULL**: both the address and the data have arrived.

The transitions are:
- **take_addr**: ENT_FREE to ENT_ADDR, and ENT_DATA to ENT_FULL.
- **take_data**: ENT_FREE to ENT_DATA, and ENT_ADDR to ENT_FULL.
- **take_both**: ENT_FREE to ENT_FULL.
- **release**: any state to ENT_FREE.

Top module: `sfw_unit`

## Requirements
- R1: After reset every entry is in ENT_FREE with a zero byte-enable, and every result output is zero.
- R2: While `ld_valid` is 0, the stage-1 outputs are zero in that cycle, and the stage-2 outputs are zero in the following cycle.
- R3: Byte lane b (bits 8b+7..8b) forwards from an entry when all of these hold: its bit in `ld_older` is set, it holds an address and data (ENT_FULL), its virtual doubleword address equals `ld_vaddr_hi`, and bit b is set in both its byte-enable and `ld_mask`. Lanes that do not forward read as zero in `fwd_data`.
- R4: The set bits of `ld_older` form one circular run. The youngest older entry is the last entry of that run, or entry SQ_DEPTH-1 when every bit is set. When several entries qualify for a lane, the one nearest the youngest older entry wins.
- R5: For a query presented in cycle t, `fwd_mask_fast` reports the forward vector in cycle t. `fwd_mask` and `fwd_data` report the same vector and the merged bytes in cycle t+1.
- R6: An entry is blocking when it is older, holds an address but no data (ENT_ADDR), matches `ld_vaddr_hi`, and its byte-enable overlaps `ld_mask`. When any entry is blocking, `data_wait_fast` is 1 in cycle t. In cycle t+1 `data_wait` is 1 and `data_wait_idx` is the blocking entry nearest the youngest older entry. With no blocking entry both flags are 0 and the index is 0.
- R7: In cycle t+1, `match_bad` is 1 exactly when two sets of entries differ. The first set is the older, address-holding entries whose virtual doubleword address equals `ld_vaddr_hi`. The second set is the same entries matched by physical doubleword address against `ld_paddr_hi`. Byte-enables are ignored here.
- R8: A byte-enable write requested before clock edge k is not visible to queries after edge k. It is visible after edge k+1.
- R9: Entry transitions follow take_addr, take_data, take_both and release. A release wins over an address or data write to the same entry in the same cycle, and it clears the byte-enable.
- R10: Entries whose `ld_older` bit is clear never forward, block, or take part in the match-disagreement check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_addr_we | input | 1 | Write addresses into an entry |
| st_addr_idx | input | IDX_W | Entry for the address write |
| st_vaddr_hi | input | VA_W-3 | Store virtual doubleword address |
| st_paddr_hi | input | PA_W-3 | Store physical doubleword address |
| st_data_we | input | 1 | Write data into an entry |
| st_data_idx | input | IDX_W | Entry for the data write |
| st_data | input | 64 | Store data |
| st_mask_we | input | 1 | Request a byte-enable write (two-cycle path) |
| st_mask_idx | input | IDX_W | Entry for the byte-enable write |
| st_mask | input | 8 | Store byte-enable |
| st_free_we | input | 1 | Release an entry |
| st_free_idx | input | IDX_W | Entry to release |
| ld_valid | input | 1 | Query present this cycle |
| ld_vaddr_hi | input | VA_W-3 | Load virtual doubleword address |
| ld_paddr_hi | input | PA_W-3 | Load physical doubleword address |
| ld_mask | input | 8 | Load byte-enable |
| ld_older | input | SQ_DEPTH | Entries older than the load |
| fwd_mask_fast | output | 8 | Stage-1 forward vector |
| data_wait_fast | output | 1 | Stage-1 data-pending flag |
| fwd_mask | output | 8 | Stage-2 forward vector |
| fwd_data | output | 64 | Stage-2 forwarded bytes |
| data_wait | output | 1 | Stage-2 data-pending flag |
| data_wait_idx | output | IDX_W | Stage-2 blocking entry index |
| match_bad | output | 1 | Stage-2 virtual/physical match disagreement |

## Verification
A wrong lifecycle state shows in the very next query to that entry. It appears either as a lane that forwards without data, or as a missing or spurious data-pending flag with the wrong index. A wrong youngest-entry selection shows as wrong bytes in `fwd_data` or a wrong `data_wait_idx` one cycle after the query. A byte-enable written too early or too late shows as a changed `fwd_mask_fast` one edge away from where R8 places it. The sweep covers every circular run of older entries for each filled queue, so these errors surface within a few queries.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
    localparam int LANES  = 8;
    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_ADDR = 2'd1,
        ENT_DATA = 2'd2,
        ENT_FULL = 2'd3
    } ent_state_e;
endpackage

// File: rtl/sfw_entry.sv
module sfw_entry
    import sfw_pkg::*;
#(
    parameter int VW_W = 36,
    parameter int PW_W = 33
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_we,
    input  logic [VW_W-1:0]      vaddr_in,
    input  logic [PW_W-1:0]      paddr_in,
    input  logic                 data_we,
    input  logic [DATA_W-1:0]    data_in,
    input  logic                 mask_we,
    input  logic [LANES-1:0]     mask_in,
    input  logic                 free_we,
    output logic                 addr_ok,
    output logic                 data_ok,
    output logic [VW_W-1:0]      vaddr_q,
    output logic [PW_W-1:0]      paddr_q,
    output logic [LANES-1:0]     mask_q,
    output logic [DATA_W-1:0]    data_q
);
    ent_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    // transitions: release dominates
    always_comb begin
        state_d = state_q;
        if (free_we) begin
            state_d = ENT_FREE;
        end else begin
            unique case (state_q)
                ENT_FREE: begin
                    if (addr_we && data_we) state_d = ENT_FULL;
                    else if (addr_we)       state_d = ENT_ADDR;
                    else if (data_we)       state_d = ENT_DATA;
                end
                ENT_ADDR: if (data_we) state_d = ENT_FULL;
                ENT_DATA: if (addr_we) state_d = ENT_FULL;
                ENT_FULL: state_d = ENT_FULL;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        addr_ok = (state_q == ENT_ADDR) || (state_q == ENT_FULL);
        data_ok = (state_q == ENT_DATA) || (state_q == ENT_FULL);
    end

    // payload storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            paddr_q <= '0;
            data_q  <= '0;
            mask_q  <= '0;
        end else begin
            if (addr_we && !free_we) begin
                vaddr_q <= vaddr_in;
                paddr_q <= paddr_in;
            end
            if (data_we && !free_we) data_q <= data_in;
            if (free_we)             mask_q <= '0;
            else if (mask_we)        mask_q <= mask_in;
        end
    end
endmodule

// File: rtl/sfw_mask_pipe.sv
module sfw_mask_pipe
    import sfw_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_we,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [LANES-1:0]  req_mask,
    output logic [DEPTH-1:0]  wr_en,
    output logic [LANES-1:0]  wr_mask
);
    logic             pend_v;
    logic [IDX_W-1:0] pend_idx;
    logic [LANES-1:0] pend_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_idx  <= '0;
            pend_mask <= '0;
        end else begin
            pend_v    <= req_we;
            pend_idx  <= req_idx;
            pend_mask <= req_mask;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_dec
        assign wr_en[g] = pend_v && (pend_idx == IDX_W'(g));
    end
    assign wr_mask = pend_mask;
endmodule

// File: rtl/sfw_lookup.sv
module sfw_lookup
    import sfw_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int VW_W  = 36,
    parameter int PW_W  = 33
) (
    input  logic                         q_valid,
    input  logic [VW_W-1:0]              q_vhi,
    input  logic [PW_W-1:0]              q_phi,
    input  logic [LANES-1:0]             q_mask,
    input  logic [DEPTH-1:0]             q_older,
    input  logic [DEPTH-1:0]             e_addr_ok,
    input  logic [DEPTH-1:0]             e_data_ok,
    input  logic [DEPTH-1:0][VW_W-1:0]   e_vhi,
    input  logic [DEPTH-1:0][PW_W-1:0]   e_phi,
    input  logic [DEPTH-1:0][LANES-1:0]  e_mask,
    input  logic [DEPTH-1:0][DATA_W-1:0] e_data,
    output logic [LANES-1:0]             f_mask,
    output logic [DATA_W-1:0]            f_data,
    output logic                         wait_any,
    output logic [IDX_W-1:0]             wait_idx,
    output logic                         addr_bad
);
    logic [IDX_W-1:0] tail;
    logic [DEPTH-1:0] v_hit, p_hit, ovl;

    // youngest older entry: end of the circular run
    always_comb begin
        tail = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q_older[i] && !q_older[(i + 1) % DEPTH]) tail = IDX_W'(i);
        end
        if (&q_older) tail = IDX_W'(DEPTH - 1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign v_hit[g] = q_valid && q_older[g] && e_addr_ok[g] && (e_vhi[g] == q_vhi);
        assign p_hit[g] = q_valid && q_older[g] && e_addr_ok[g] && (e_phi[g] == q_phi);
        assign ovl[g]   = |(e_mask[g] & q_mask);
    end

    // oldest-to-youngest scan: later hits overwrite earlier ones
    always_comb begin
        logic [IDX_W-1:0] sel;
        f_mask   = '0;
        f_data   = '0;
        wait_any = 1'b0;
        wait_idx = '0;
        for (int k = 0; k < DEPTH; k++) begin
            sel = IDX_W'((int'(tail) + 1 + k) % DEPTH);
            if (v_hit[sel] && e_data_ok[sel]) begin
                for (int b = 0; b < LANES; b++) begin
                    if (q_mask[b] && e_mask[sel][b]) begin
                        f_mask[b]       = 1'b1;
                        f_data[b*8 +: 8] = e_data[sel][b*8 +: 8];
                    end
                end
            end else if (v_hit[sel] && ovl[sel]) begin
                wait_any = 1'b1;
                wait_idx = sel;
            end
        end
    end

    assign addr_bad = (v_hit != p_hit);
endmodule

// File: rtl/sfw_unit.sv
module sfw_unit
    import sfw_pkg::*;
#(
    parameter int SQ_DEPTH = 8,
    parameter int VA_W     = 39,
    parameter int PA_W     = 36,
    localparam int IDX_W   = $clog2(SQ_DEPTH),
    localparam int VW_W    = VA_W - 3,
    localparam int PW_W    = PA_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_addr_we,
    input  logic [IDX_W-1:0]  st_addr_idx,
    input  logic [VW_W-1:0]   st_vaddr_hi,
    input  logic [PW_W-1:0]   st_paddr_hi,
    input  logic              st_data_we,
    input  logic [IDX_W-1:0]  st_data_idx,
    input  logic [63:0]       st_data,
    input  logic              st_mask_we,
    input  logic [IDX_W-1:0]  st_mask_idx,
    input  logic [7:0]        st_mask,
    input  logic              st_free_we,
    input  logic [IDX_W-1:0]  st_free_idx,
    input  logic              ld_valid,
    input  logic [VW_W-1:0]   ld_vaddr_hi,
    input  logic [PW_W-1:0]   ld_paddr_hi,
    input  logic [7:0]        ld_mask,
    input  logic [SQ_DEPTH-1:0] ld_older,
    output logic [7:0]        fwd_mask_fast,
    output logic              data_wait_fast,
    output logic [7:0]        fwd_mask,
    output logic [63:0]       fwd_data,
    output logic              data_wait,
    output logic [IDX_W-1:0]  data_wait_idx,
    output logic              match_bad
);
    logic [SQ_DEPTH-1:0]              mwr_en;
    logic [LANES-1:0]                 mwr_mask;
    logic [SQ_DEPTH-1:0]              e_addr_ok, e_data_ok;
    logic [SQ_DEPTH-1:0][VW_W-1:0]    e_vhi;
    logic [SQ_DEPTH-1:0][PW_W-1:0]    e_phi;
    logic [SQ_DEPTH-1:0][LANES-1:0]   e_mask;
    logic [SQ_DEPTH-1:0][DATA_W-1:0]  e_data;

    logic [LANES-1:0]  s1_mask;
    logic [DATA_W-1:0] s1_data;
    logic              s1_wait;
    logic [IDX_W-1:0]  s1_idx;
    logic              s1_bad;

    sfw_mask_pipe #(.DEPTH(SQ_DEPTH), .IDX_W(IDX_W)) mask_pipe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_we   (st_mask_we),
        .req_idx  (st_mask_idx),
        .req_mask (st_mask),
        .wr_en    (mwr_en),
        .wr_mask  (mwr_mask)
    );

    for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_ent
        sfw_entry #(.VW_W(VW_W), .PW_W(PW_W)) ent_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr_we  (st_addr_we && (st_addr_idx == IDX_W'(g))),
            .vaddr_in (st_vaddr_hi),
            .paddr_in (st_paddr_hi),
            .data_we  (st_data_we && (st_data_idx == IDX_W'(g))),
            .data_in  (st_data),
            .mask_we  (mwr_en[g]),
            .mask_in  (mwr_mask),
            .free_we  (st_free_we && (st_free_idx == IDX_W'(g))),
            .addr_ok  (e_addr_ok[g]),
            .data_ok  (e_data_ok[g]),
            .vaddr_q  (e_vhi[g]),
            .paddr_q  (e_phi[g]),
            .mask_q   (e_mask[g]),
            .data_q   (e_data[g])
        );
    end

    sfw_lookup #(.DEPTH(SQ_DEPTH), .IDX_W(IDX_W), .VW_W(VW_W), .PW_W(PW_W)) lookup_i (
        .q_valid   (ld_valid),
        .q_vhi     (ld_vaddr_hi),
        .q_phi     (ld_paddr_hi),
        .q_mask    (ld_mask),
        .q_older   (ld_older),
        .e_addr_ok (e_addr_ok),
        .e_data_ok (e_data_ok),
        .e_vhi     (e_vhi),
        .e_phi     (e_phi),
        .e_mask    (e_mask),
        .e_data    (e_data),
        .f_mask    (s1_mask),
        .f_data    (s1_data),
        .wait_any  (s1_wait),
        .wait_idx  (s1_idx),
        .addr_bad  (s1_bad)
    );

    assign fwd_mask_fast  = s1_mask;
    assign data_wait_fast = s1_wait;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_mask      <= '0;
            fwd_data      <= '0;
            data_wait     <= 1'b0;
            data_wait_idx <= '0;
            match_bad     <= 1'b0;
        end else begin
            fwd_mask      <= s1_mask;
            fwd_data      <= s1_data;
            data_wait     <= s1_wait;
            data_wait_idx <= s1_idx;
            match_bad     <= s1_bad;
        end
    end
endmodule

// File: rtl/sfw_unit_chk.sv
module sfw_unit_chk #(
    parameter int SQ_DEPTH = 8,
    localparam int IDX_W   = $clog2(SQ_DEPTH)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ld_valid,
    input logic [SQ_DEPTH-1:0] ld_older,
    input logic [7:0]          fwd_mask_fast,
    input logic                data_wait_fast,
    input logic [7:0]          fwd_mask,
    input logic [63:0]         fwd_data,
    input logic                data_wait,
    input logic [IDX_W-1:0]    data_wait_idx,
    input logic                match_bad
);
    logic [63:0] hole;
    always_comb begin
        for (int b = 0; b < 8; b++) hole[b*8 +: 8] = {8{~fwd_mask[b]}};
    end

    // R2
    idle_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> (fwd_mask_fast == 8'h00 && !data_wait_fast));

    // R2
    idle_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ld_valid) |-> (fwd_mask == 8'h00 && !data_wait && !match_bad));

    // R5
    mask_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_mask == $past(fwd_mask_fast));

    // R6
    wait_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wait == $past(data_wait_fast));

    // R6
    wait_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wait |-> data_wait_idx == '0);

    // R3
    dead_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_data & hole) == 64'h0);

    // R10
    no_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_older == '0) |-> (fwd_mask_fast == 8'h00 && !data_wait_fast));
endmodule

bind sfw_unit sfw_unit_chk #(.SQ_DEPTH(SQ_DEPTH)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ld_valid       (ld_valid),
    .ld_older       (ld_older),
    .fwd_mask_fast  (fwd_mask_fast),
    .data_wait_fast (data_wait_fast),
    .fwd_mask       (fwd_mask),
    .fwd_data       (fwd_data),
    .data_wait      (data_wait),
    .data_wait_idx  (data_wait_idx),
    .match_bad      (match_bad)
);

// File: tb/sfw_unit_tb_top.sv
`timescale 1ns/1ps
module sfw_unit_tb_top;
    localparam int N    = 8;
    localparam int IW   = 3;
    localparam int VW   = 36;
    localparam int PW   = 33;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          st_addr_we = 0, st_data_we = 0, st_mask_we = 0, st_free_we = 0;
    logic [IW-1:0] st_addr_idx = 0, st_data_idx = 0, st_mask_idx = 0, st_free_idx = 0;
    logic [VW-1:0] st_vaddr_hi = 0;
    logic [PW-1:0] st_paddr_hi = 0;
    logic [63:0]   st_data = 0;
    logic [7:0]    st_mask = 0;
    logic          ld_valid = 0;
    logic [VW-1:0] ld_vaddr_hi = 0;
    logic [PW-1:0] ld_paddr_hi = 0;
    logic [7:0]    ld_mask = 0;
    logic [N-1:0]  ld_older = 0;
    logic [7:0]    fwd_mask_fast, fwd_mask;
    logic          data_wait_fast, data_wait, match_bad;
    logic [63:0]   fwd_data;
    logic [IW-1:0] data_wait_idx;

    sfw_unit dut_i (.*);

    int n_chk = 0, n_bad = 0;
    logic [31:0] rs = 32'h1234_5679;

    bit          m_av [N];
    bit          m_dv [N];
    int          m_va [N];
    int          m_pa [N];
    logic [7:0]  m_mk [N];
    logic [63:0] m_dt [N];

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask

    task automatic wr_addr(input int i, input int va, input int pa);
        cyc(); st_addr_we = 1; st_addr_idx = IW'(i); st_vaddr_hi = VW'(va); st_paddr_hi = PW'(pa);
        cyc(); st_addr_we = 0;
        m_av[i] = 1; m_va[i] = va; m_pa[i] = pa;
    endtask
    task automatic wr_data(input int i, input logic [63:0] d);
        cyc(); st_data_we = 1; st_data_idx = IW'(i); st_data = d;
        cyc(); st_data_we = 0;
        m_dv[i] = 1; m_dt[i] = d;
    endtask
    task automatic wr_mask(input int i, input logic [7:0] m);
        cyc(); st_mask_we = 1; st_mask_idx = IW'(i); st_mask = m;
        cyc(); st_mask_we = 0;
        cyc();
        m_mk[i] = m;
    endtask
    task automatic release_ent(input int i);
        cyc(); st_free_we = 1; st_free_idx = IW'(i);
        cyc(); st_free_we = 0;
        m_av[i] = 0; m_dv[i] = 0; m_mk[i] = 0;
    endtask

    // reference: scan youngest to oldest from the given tail
    task automatic model(input logic [N-1:0] older, input int tail, input int va, input int pa,
                         input logic [7:0] lm, output logic [7:0] em, output logic [63:0] ed,
                         output bit ew, output int ei, output bit eb);
        logic [N-1:0] vs, ps;
        em = 0; ed = 0; ew = 0; ei = 0; vs = 0; ps = 0;
        for (int k = 0; k < N; k++) begin
            int i;
            i = (tail - k + N) % N;
            if (older[i] && m_av[i]) begin
                vs[i] = (m_va[i] == va);
                ps[i] = (m_pa[i] == pa);
                if (m_va[i] == va && (m_mk[i] & lm) != 0) begin
                    if (m_dv[i]) begin
                        for (int b = 0; b < 8; b++)
                            if (!em[b] && lm[b] && m_mk[i][b]) begin
                                em[b] = 1; ed[b*8 +: 8] = m_dt[i][b*8 +: 8];
                            end
                    end else if (!ew) begin
                        ew = 1; ei = i;
                    end
                end
            end
        end
        eb = (vs != ps);
    endtask

    task automatic query(input logic [N-1:0] older, input int tail, input int va, input int pa,
                         input logic [7:0] lm, input string tag);
        logic [7:0] em; logic [63:0] ed; bit ew; int ei; bit eb;
        model(older, tail, va, pa, lm, em, ed, ew, ei, eb);
        cyc();
        ld_valid = 1; ld_older = older; ld_vaddr_hi = VW'(va); ld_paddr_hi = PW'(pa); ld_mask = lm;
        #2;
        chk({fwd_mask_fast, data_wait_fast} == {em, ew}, {tag, " R5 stage1"},
            {fwd_mask_fast, data_wait_fast}, {em, ew});
        cyc();
        ld_valid = 0;
        chk({fwd_mask, fwd_data, data_wait, data_wait_idx, match_bad} ==
            {em, ed, ew, IW'(ei), eb}, {tag, " stage2"},
            {fwd_mask, fwd_data, data_wait, data_wait_idx, match_bad}, {em, ed, ew, IW'(ei), eb});
    endtask

    function automatic logic [N-1:0] run_mask(input int tail, input int len);
        logic [N-1:0] m = 0;
        for (int k = 0; k < len; k++) m[(tail - k + N) % N] = 1'b1;
        return m;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=expired exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < N; i++) begin
            m_av[i] = 0; m_dv[i] = 0; m_va[i] = 0; m_pa[i] = 0; m_mk[i] = 0; m_dt[i] = 0;
        end
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1: reset outputs and empty queue
        chk({fwd_mask, fwd_data, data_wait, data_wait_idx, match_bad} == '0, "R1 reset outputs",
            {fwd_mask, fwd_data, data_wait, match_bad}, 0);
        query('1, N-1, 0, 0, 8'hFF, "R1 empty queue");

        // R9: address only -> blocking entry
        wr_addr(3, 5, 21);
        wr_mask(3, 8'h0F);
        query(8'b0000_1000, 3, 5, 21, 8'h01, "R9 ENT_ADDR blocks R6");
        wr_data(3, 64'h1122_3344_5566_7788);
        query(8'b0000_1000, 3, 5, 21, 8'h33, "R9 ENT_FULL forwards R3");
        // R10: same entry outside older run
        query(8'b0000_0100, 2, 5, 21, 8'hFF, "R10 excluded entry");
        // R9: release wins over same-cycle writes
        cyc(); st_free_we = 1; st_free_idx = 3; st_addr_we = 1; st_addr_idx = 3;
        st_vaddr_hi = 5; st_paddr_hi = 21; st_data_we = 1; st_data_idx = 3;
        cyc(); st_free_we = 0; st_addr_we = 0; st_data_we = 0;
        m_av[3] = 0; m_dv[3] = 0; m_mk[3] = 0;
        query(8'b0000_1000, 3, 5, 21, 8'hFF, "R9 release wins");
        // R9: data first then address
        wr_data(4, 64'hA5A5_A5A5_A5A5_A5A5);
        wr_mask(4, 8'hF0);
        query(8'b0001_0000, 4, 7, 23, 8'hF0, "R9 ENT_DATA silent");
        wr_addr(4, 7, 23);
        query(8'b0001_0000, 4, 7, 23, 8'hF0, "R9 ENT_DATA to ENT_FULL");

        // R8: byte-enable write latency
        cyc(); st_mask_we = 1; st_mask_idx = 4; st_mask = 8'h0F;
        cyc(); st_mask_we = 0;
        ld_valid = 1; ld_older = 8'b0001_0000; ld_vaddr_hi = 7; ld_paddr_hi = 23; ld_mask = 8'hFF;
        #2 chk(fwd_mask_fast == 8'hF0, "R8 not yet visible", fwd_mask_fast, 8'hF0);
        cyc();
        #2 chk(fwd_mask_fast == 8'h0F, "R8 visible after two edges", fwd_mask_fast, 8'h0F);
        ld_valid = 0;
        m_mk[4] = 8'h0F;

        // R2: fields driven but query not valid
        cyc(); ld_older = '1; ld_vaddr_hi = 7; ld_paddr_hi = 23; ld_mask = 8'hFF;
        #2 chk({fwd_mask_fast, data_wait_fast} == 0, "R2 idle stage1", {fwd_mask_fast, data_wait_fast}, 0);
        cyc();
        chk({fwd_mask, data_wait, match_bad} == 0, "R2 idle stage2", {fwd_mask, data_wait, match_bad}, 0);

        // sweep: R3 R4 R6 R7 R10 over many filled queues and all older runs
        for (int sc = 0; sc < 6; sc++) begin
            for (int i = 0; i < N; i++) begin
                int va;
                logic [31:0] r;
                release_ent(i);
                r  = rnd();
                va = int'(r[1:0]);
                if (r[7:4] != 0) wr_addr(i, va, (sc % 2 == 1 && r[10:8] == 0) ? va + 17 : va + 16);
                if (r[13:12] != 0) wr_data(i, {rnd(), rnd()});
                wr_mask(i, 8'(rnd()));
            end
            for (int tl = 0; tl < N; tl++) begin
                for (int ln = 0; ln <= N; ln++) begin
                    if (ln == N && tl != N - 1) continue;
                    for (int va = 0; va < 4; va++) begin
                        logic [7:0] lm;
                        lm = (va == 0) ? 8'hFF : 8'(rnd());
                        query(run_mask(tl, ln), tl, va, va + 16, lm,
                              (ln == 0) ? "R10 empty run" : "R4 R3 R6 R7 sweep");
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule